// File: doc/BRIEF.md
# BCD Calendar Clock

This block keeps wall-clock time and calendar date in packed BCD. A free-running tick enable feeds a sub-second prescaler. After `TICKS_PER_SEC` enabled ticks the seconds field advances, and carries ripple through minutes, hours, date, month and year in the same clock cycle. A day-of-week counter advances alongside the date.

A host reads and overwrites the seven fields through a small register port. Reads are combinational. A write lands on the next clock edge. The hours field runs in either 24-hour or 12-hour form, and the mode flag and the afternoon flag are stored inside the hours register itself. An oscillator-disable input freezes all counting while it is high.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the fields read seconds 0x00, minutes 0x00, hours 0x00 (24-hour form), weekday 0x01, date 0x01, month 0x01 and year 0x00.
- R2: The fields sit at addresses 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 date, 5 month and 6 year. A write is read back with its unused bits cleared (seconds and minutes keep bits 6:0, hours bits 6:0, weekday bits 2:0, date bits 5:0, month bits 4:0, year bits 7:0). Address 7 reads 0x00, and a write to it changes nothing.
- R3: Seconds advance once for every `TICKS_PER_SEC` ticks taken while counting is enabled. Seconds and minutes wrap from 0x59 to 0x00, and each wrap carries into the next field.
- R4: In 24-hour form (hours bit 6 clear) hours run from 0x00 to 0x23. The step from 0x23 to 0x00 advances the date.
- R5: In 12-hour form (hours bit 6 set, bit 5 set meaning PM, bits 4:0 holding BCD 1 to 12) the sequence is 11 AM to 12 PM to 1 PM, and 11 PM to 12 AM to 1 AM. The PM flag flips on the step into 12. Only the step from 11 PM into 12 AM advances the date.
- R6: The weekday runs 1 to 7 and wraps from 7 to 1 each time the date advances, independently of the date value.
- R7: The date wraps to 0x01 after 0x31 in 31-day months, after 0x30 in April, June, September and November, and in February after 0x29 when the year's value is divisible by 4 and after 0x28 otherwise.
- R8: The month wraps from 0x12 to 0x01 and carries into the year. The year wraps from 0x99 to 0x00.
- R9: While `osc_off` is high no field changes from ticks, but host writes still take effect. Counting resumes when `osc_off` falls.
- R10: A write to any field clears the prescaler, so the next seconds step needs a full `TICKS_PER_SEC` ticks after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaler enable pulse |
| osc_off | input | 1 | High freezes counting |
| wr_en | input | 1 | Write strobe for the addressed field |
| addr | input | 3 | Field address |
| wr_data | input | 8 | Write value (BCD with flag bits) |
| rd_data | output | 8 | Addressed field, combinational |

## Verification
The bench builds the block with `TICKS_PER_SEC` = 4. At that setting every second lasts four clock cycles, so the bench can place each field one step before its wrap and reach the full carry chain from 23:59:59 on the last day of year 99. The same short second makes the leap-year cases for February, the 12-hour noon and midnight crossings, and the prescaler restart after a write cheap to hit exactly.

// File: rtl/bcd_calendar.sv
module bcd_calendar #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       osc_off,
  input  logic       wr_en,
  input  logic [2:0] addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data
);
  localparam int PW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [PW-1:0] PLAST = PW'(TICKS_PER_SEC - 1);

  logic [PW-1:0] presc_q;
  logic [7:0] sec_q, min_q, hour_q, wday_q, date_q, mon_q, year_q;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
  endfunction

  logic       step, sec_wrap, min_wrap, day_carry, date_wrap, mon_wrap, leap;
  logic [7:0] hour_nx, last_day, year_bin;

  assign step     = tick && !osc_off && (presc_q == PLAST);
  assign sec_wrap = (sec_q == 8'h59);
  assign min_wrap = (min_q == 8'h59);
  assign date_wrap = (date_q == last_day);
  assign mon_wrap = (mon_q == 8'h12);
  assign year_bin = {4'd0, year_q[7:4]} * 8'd10 + {4'd0, year_q[3:0]};
  assign leap     = (year_bin[1:0] == 2'b00);

  always_comb begin
    case (mon_q)
      8'h02:                      last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end

  always_comb begin
    day_carry = 1'b0;
    if (hour_q[6]) begin
      if (hour_q[4:0] == 5'h12)
        hour_nx = {2'b01, hour_q[5], 5'h01};
      else if (hour_q[4:0] == 5'h11) begin
        hour_nx   = {2'b01, ~hour_q[5], 5'h12};
        day_carry = hour_q[5];
      end else
        hour_nx = {2'b01, hour_q[5], bcd_inc({3'd0, hour_q[4:0]})[4:0]};
    end else if (hour_q == 8'h23) begin
      hour_nx   = 8'h00;
      day_carry = 1'b1;
    end else
      hour_nx = bcd_inc(hour_q);
  end

  always_comb begin
    case (addr)
      3'd0:    rd_data = sec_q;
      3'd1:    rd_data = min_q;
      3'd2:    rd_data = hour_q;
      3'd3:    rd_data = wday_q;
      3'd4:    rd_data = date_q;
      3'd5:    rd_data = mon_q;
      3'd6:    rd_data = year_q;
      default: rd_data = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
      sec_q  <= 8'h00; min_q  <= 8'h00; hour_q <= 8'h00; wday_q <= 8'h01;
      date_q <= 8'h01; mon_q  <= 8'h01; year_q <= 8'h00;
    end else if (wr_en) begin
      presc_q <= '0;
      case (addr)
        3'd0: sec_q  <= wr_data & 8'h7F;
        3'd1: min_q  <= wr_data & 8'h7F;
        3'd2: hour_q <= wr_data & 8'h7F;
        3'd3: wday_q <= wr_data & 8'h07;
        3'd4: date_q <= wr_data & 8'h3F;
        3'd5: mon_q  <= wr_data & 8'h1F;
        3'd6: year_q <= wr_data;
        default: ;
      endcase
    end else if (tick && !osc_off) begin
      presc_q <= step ? '0 : presc_q + 1'b1;
      if (step) begin
        sec_q <= sec_wrap ? 8'h00 : bcd_inc(sec_q);
        if (sec_wrap) begin
          min_q <= min_wrap ? 8'h00 : bcd_inc(min_q);
          if (min_wrap) begin
            hour_q <= hour_nx;
            if (day_carry) begin
              wday_q <= (wday_q == 8'h07) ? 8'h01 : wday_q + 8'h01;
              date_q <= date_wrap ? 8'h01 : bcd_inc(date_q);
              if (date_wrap) begin
                mon_q <= mon_wrap ? 8'h01 : bcd_inc(mon_q);
                if (mon_wrap) year_q <= (year_q == 8'h99) ? 8'h00 : bcd_inc(year_q);
              end
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/bcd_calendar_chk.sv
module bcd_calendar_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       osc_off,
  input logic       wr_en,
  input logic [2:0] addr,
  input logic [7:0] wr_data,
  input logic [7:0] sec_q,
  input logic [7:0] min_q,
  input logic [7:0] hour_q
);
  // R9
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_off && !wr_en) |=> ($stable(sec_q) && $stable(min_q) && $stable(hour_q)));

  // R3
  no_tick_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> $stable(sec_q));

  // R2
  sec_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd0) |=> (sec_q == ($past(wr_data) & 8'h7F)));

  // R3
  min_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((min_q == $past(min_q)) || (sec_q == 8'h00)));

  // R4
  hour_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((hour_q == $past(hour_q)) || (min_q == 8'h00)));
endmodule

bind bcd_calendar bcd_calendar_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .osc_off(osc_off), .wr_en(wr_en),
  .addr(addr), .wr_data(wr_data), .sec_q(sec_q), .min_q(min_q), .hour_q(hour_q)
);

// File: tb/bcd_calendar_test.sv
module bcd_calendar_test;
  localparam int TPS = 4;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, osc_off = 1'b0, wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  int vectors = 0, errors = 0;

  always #4 clk = ~clk;

  bcd_calendar #(.TICKS_PER_SEC(TPS)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .osc_off(osc_off), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data));

  task automatic expect_reg(input string req, input logic [2:0] a, input logic [7:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    vectors++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s addr %0d: got %02h expected %02h", req, a, rd_data, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic set_all(input logic [7:0] s, m, h, w, d, mo, y);
    wr(0, s); wr(1, m); wr(2, h); wr(3, w); wr(4, d); wr(5, mo); wr(6, y);
  endtask

  task automatic t_reset;
    expect_reg("R1", 0, 8'h00); expect_reg("R1", 1, 8'h00); expect_reg("R1", 2, 8'h00);
    expect_reg("R1", 3, 8'h01); expect_reg("R1", 4, 8'h01); expect_reg("R1", 5, 8'h01);
    expect_reg("R1", 6, 8'h00);
  endtask

  task automatic t_regs;
    wr(0, 8'hC5); expect_reg("R2", 0, 8'h45);
    wr(3, 8'hFE); expect_reg("R2", 3, 8'h06);
    wr(6, 8'h87); expect_reg("R2", 6, 8'h87);
    wr(7, 8'h33); expect_reg("R2", 7, 8'h00);
    expect_reg("R2", 0, 8'h45); expect_reg("R2", 6, 8'h87);
  endtask

  task automatic t_seconds;
    set_all(8'h58, 8'h59, 8'h05, 8'h02, 8'h10, 8'h03, 8'h21);
    ticks(TPS);     expect_reg("R3", 0, 8'h59); expect_reg("R3", 1, 8'h59);
    ticks(TPS);     expect_reg("R3", 0, 8'h00); expect_reg("R3", 1, 8'h00);
    expect_reg("R3", 2, 8'h06);
    ticks(TPS * 3); expect_reg("R3", 0, 8'h03);
  endtask

  task automatic t_full_carry;
    set_all(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
    ticks(TPS);
    expect_reg("R4", 2, 8'h00); expect_reg("R6", 3, 8'h01); expect_reg("R8", 4, 8'h01);
    expect_reg("R8", 5, 8'h01); expect_reg("R8", 6, 8'h00);
  endtask

  task automatic t_twelve;
    set_all(8'h59, 8'h59, 8'h51, 8'h03, 8'h05, 8'h06, 8'h22);
    ticks(TPS); expect_reg("R5", 2, 8'h72); expect_reg("R5", 4, 8'h05);
    wr(0, 8'h59); wr(1, 8'h59);
    ticks(TPS); expect_reg("R5", 2, 8'h61);
    wr(0, 8'h59); wr(1, 8'h59); wr(2, 8'h71);
    ticks(TPS); expect_reg("R5", 2, 8'h52); expect_reg("R5", 4, 8'h06);
    expect_reg("R6", 3, 8'h04);
    wr(0, 8'h59); wr(1, 8'h59);
    ticks(TPS); expect_reg("R5", 2, 8'h41);
  endtask

  task automatic t_months;
    set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h24);
    ticks(TPS); expect_reg("R7", 4, 8'h29); expect_reg("R7", 5, 8'h02);
    wr(0, 8'h59); wr(1, 8'h59); wr(2, 8'h23);
    ticks(TPS); expect_reg("R7", 4, 8'h01); expect_reg("R7", 5, 8'h03);
    set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h23);
    ticks(TPS); expect_reg("R7", 4, 8'h01); expect_reg("R7", 5, 8'h03);
    set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h00);
    ticks(TPS); expect_reg("R7", 4, 8'h29);
    set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h10);
    ticks(TPS); expect_reg("R7", 4, 8'h01); expect_reg("R7", 5, 8'h05);
    set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h08, 8'h10);
    ticks(TPS); expect_reg("R7", 4, 8'h31);
    set_all(8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h41);
    ticks(TPS); expect_reg("R8", 5, 8'h01); expect_reg("R8", 6, 8'h42);
  endtask

  task automatic t_halt;
    wr(0, 8'h10);
    osc_off = 1'b1;
    ticks(TPS * 3); expect_reg("R9", 0, 8'h10);
    wr(1, 8'h33); expect_reg("R9", 1, 8'h33);
    osc_off = 1'b0;
    ticks(TPS); expect_reg("R9", 0, 8'h11);
  endtask

  task automatic t_prescale;
    wr(0, 8'h20);
    ticks(TPS - 1); expect_reg("R10", 0, 8'h20);
    wr(0, 8'h30);
    ticks(TPS - 1); expect_reg("R10", 0, 8'h30);
    ticks(1);       expect_reg("R10", 0, 8'h31);
  endtask

  initial begin
    #2_000_000;
    errors++; vectors++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_seconds();
    t_full_carry();
    t_twelve();
    t_months();
    t_halt();
    t_prescale();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule